// File: doc/BRIEF.md
# Tagged Quadword Pointer-Load Unit

This block carries out a load of one 16-byte quadword whose integrity as a pointer is checked on the way. It holds its own small memory of quadwords. Next to each aligned quadword the memory keeps one tag bit, stored apart from the 16 data bytes. A pointer store sets the tag, and any ordinary store to that quadword clears it. A load adds a signed displacement to a base register value to form the effective address. It reads the quadword and writes its two doublewords into an even/odd register pair.

While the load runs, the unit tests the quadword as a pointer. The quadword passes when its tag is set and the pointer-type field in its first doubleword names one of the kinds selected by a 4-bit mask from the instruction. The outcome sets or clears one fixed bit of a 16-bit extended exception field. A later select operation can then keep the loaded address or force it to zero. A misaligned address or an odd destination register faults: nothing is written and the exception bit keeps its value.

Top module: `tqload_unit`

## Requirements
- R1: The effective address is `ld_base_i` plus `ld_disp_i` sign-extended from 12 bits, modulo 2^32. It appears on `ld_ea_o` in the result cycle. Address bits 9:4 select the quadword, and higher bits wrap.
- R2: On a valid load, `rf0_we_o` and `rf1_we_o` are high in the cycle after the issuing clock edge, with `rf0_idx_o` = RT and `rf1_idx_o` = RT+1. `rf0_data_o` carries quadword bits 127:64 (the first doubleword) and `rf1_data_o` carries bits 63:0.
- R3: A store with `st_ptr_i`=1 sets the stored quadword's tag, and a store with `st_ptr_i`=0 clears it. Reset clears every tag but leaves the data.
- R4: The pointer type is quadword bits 67:64 (the low nibble of the first doubleword), coded 1000 system, 0100 instruction, 0010 space and 0001 data. The mask is an OR of these codes, so mask 0110 accepts instruction and space pointers and nothing else.
- R5: `flag_val_o` is 1 exactly when the tag is set, the type field has exactly one bit set, and the field ANDed with the mask is nonzero.
- R6: A type field of 0000 or with two or more bits set never matches, even if it overlaps the mask.
- R7: `flag_we_o` rises in the same cycle as the register writes. At the next edge `exc_o[9]` (architectural bit 41 of the field spanning bits 32 to 47) takes `flag_val_o`. All other bits of `exc_o` stay 0.
- R8: An effective address with nonzero bits 3:0 raises `align_err_o` in the result cycle. It writes no register, does not raise `flag_we_o`, and leaves `exc_o` unchanged.
- R9: An odd RT raises `pair_err_o` in the result cycle, with the same suppression as R8.
- R10: A store and a load to the same quadword at the same edge give the load the data and tag held before the store.
- R11: During and after reset, before any load, all write enables, `flag_we_o`, both fault outputs and `exc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | Issue a checked quadword load |
| ld_base_i | input | 32 | Base register value |
| ld_disp_i | input | 12 | Signed displacement |
| ld_rt_i | input | 5 | Destination register (even) |
| ld_mask_i | input | 4 | Accepted pointer-type mask |
| st_valid_i | input | 1 | Store one quadword into the memory |
| st_qidx_i | input | 6 | Quadword index of the store |
| st_data_i | input | 128 | Store data |
| st_ptr_i | input | 1 | 1: pointer store sets tag, 0: ordinary store clears tag |
| rf0_we_o | output | 1 | Write enable, even register |
| rf0_idx_o | output | 5 | Even register index |
| rf0_data_o | output | 64 | First doubleword |
| rf1_we_o | output | 1 | Write enable, odd register |
| rf1_idx_o | output | 5 | Odd register index |
| rf1_data_o | output | 64 | Second doubleword |
| flag_we_o | output | 1 | Exception flag update strobe |
| flag_val_o | output | 1 | Pointer check result |
| align_err_o | output | 1 | Misaligned effective address |
| pair_err_o | output | 1 | Odd destination register |
| ld_ea_o | output | 32 | Effective address of the completing load |
| exc_o | output | 16 | Extended exception field, bit 9 is the pointer flag |

## Verification
The register writes, `flag_we_o`, `flag_val_o`, both fault outputs and `ld_ea_o` are due in the cycle after the edge that samples the load. The bench reads them at the falling edge that follows that edge. `exc_o` changes one edge later, so the bench checks it at the next falling edge. Stores complete at their own edge, and the bench issues a load only after the store it depends on, except in the same-edge case of R10. The sweep covers every type field, every mask and both tag values. For each combination the bench predicts the flag from R5 and R6 by counting bits.

// File: rtl/tqload_pkg.sv
package tqload_pkg;

   localparam int QW_BITS  = 128;
   localparam int DW_BITS  = 64;
   localparam int PT_W     = 4;
   localparam int PT_LSB   = 64;   // low nibble of first doubleword
   localparam int OFS_W    = 4;    // byte offset inside a quadword

   typedef logic [QW_BITS-1:0] qword_t;
   typedef logic [DW_BITS-1:0] dword_t;
   typedef logic [PT_W-1:0]    ptype_t;

   typedef struct packed {
      logic misalign;
      logic odd_pair;
   } fault_t;

   function automatic dword_t first_dw(input qword_t q);
      return q[QW_BITS-1:DW_BITS];
   endfunction

   function automatic dword_t second_dw(input qword_t q);
      return q[DW_BITS-1:0];
   endfunction

   function automatic ptype_t ptype_of(input qword_t q);
      return q[PT_LSB +: PT_W];
   endfunction

endpackage

// File: rtl/tqload_agen.sv
module tqload_agen
   import tqload_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 12,
   parameter int IDX_W  = 6
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic [ADDR_W-1:0] ea_o,
   output logic              misalign_o,
   output logic [IDX_W-1:0]  qidx_o
);

   localparam int EXT_W = ADDR_W - DISP_W;

   initial begin
      assert (ADDR_W > DISP_W)
         else $error("tqload_agen: ADDR_W must exceed DISP_W");
      assert (ADDR_W >= OFS_W + IDX_W)
         else $error("tqload_agen: address too narrow for index");
   end

   logic [ADDR_W-1:0] disp_ext;

   generate
      if (EXT_W > 0) begin : g_sext
         assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
      end else begin : g_nosext
         assign disp_ext = disp_i;
      end
   endgenerate

   always_comb begin
      ea_o       = base_i + disp_ext;
      misalign_o = |ea_o[OFS_W-1:0];
      qidx_o     = ea_o[OFS_W +: IDX_W];
   end

endmodule

// File: rtl/tqload_mem.sv
module tqload_mem
   import tqload_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output qword_t           rd_data_o,
   output logic             rd_tag_o,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  qword_t           wr_data_i,
   input  logic             wr_ptr_i
);

   initial begin
      assert (DEPTH >= 2 && DEPTH == (1 << IDX_W))
         else $error("tqload_mem: DEPTH must be a power of two matching IDX_W");
   end

   qword_t           data_q [DEPTH];
   logic [DEPTH-1:0] tag_q;
   qword_t           rd_data_q;
   logic             rd_tag_q;

   // data array: no reset, contents survive reset
   always_ff @(posedge clk) begin
      if (wr_en_i) data_q[wr_idx_i] <= wr_data_i;
   end

   // tag array: out-of-band, cleared by reset and by ordinary stores
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tag_q <= '0;
      else if (wr_en_i) tag_q[wr_idx_i] <= wr_ptr_i;
   end

   // registered read port, old contents win on a same-edge write
   always_ff @(posedge clk) begin
      if (rd_en_i) rd_data_q <= data_q[rd_idx_i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_tag_q <= 1'b0;
      else if (rd_en_i) rd_tag_q <= tag_q[rd_idx_i];
   end

   assign rd_data_o = rd_data_q;
   assign rd_tag_o  = rd_tag_q;

   AST_PLAIN_STORE_CLEARS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_ptr_i) |=> !tag_q[$past(wr_idx_i)]);   // R3

   AST_PTR_STORE_SETS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_ptr_i) |=> tag_q[$past(wr_idx_i)]);     // R3

endmodule

// File: rtl/tqload_check.sv
module tqload_check
   import tqload_pkg::*;
#(
   parameter bit STRICT = 1'b1
) (
   input  ptype_t type_i,
   input  ptype_t mask_i,
   input  logic   tag_i,
   output logic   match_o
);

   ptype_t hit;
   logic   type_ok;

   generate
      for (genvar i = 0; i < PT_W; i++) begin : g_sel
         assign hit[i] = type_i[i] & mask_i[i];
      end

      if (STRICT) begin : g_strict
         // well-formed field: exactly one kind named
         assign type_ok = (type_i != '0) && ((type_i & (type_i - 1'b1)) == '0);
      end else begin : g_loose
         assign type_ok = 1'b1;
      end
   endgenerate

   assign match_o = tag_i & type_ok & (|hit);

endmodule

// File: rtl/tqload_unit.sv
module tqload_unit
   import tqload_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int DISP_W      = 12,
   parameter int REG_AW      = 5,
   parameter int DEPTH       = 64,
   parameter int EXC_BASE    = 32,
   parameter int EXC_W       = 16,
   parameter int FLAG_BIT    = 41,
   parameter bit STRICT_TYPE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ld_valid_i,
   input  logic [ADDR_W-1:0]        ld_base_i,
   input  logic [DISP_W-1:0]        ld_disp_i,
   input  logic [REG_AW-1:0]        ld_rt_i,
   input  logic [PT_W-1:0]          ld_mask_i,
   input  logic                     st_valid_i,
   input  logic [$clog2(DEPTH)-1:0] st_qidx_i,
   input  logic [QW_BITS-1:0]       st_data_i,
   input  logic                     st_ptr_i,
   output logic                     rf0_we_o,
   output logic [REG_AW-1:0]        rf0_idx_o,
   output logic [DW_BITS-1:0]       rf0_data_o,
   output logic                     rf1_we_o,
   output logic [REG_AW-1:0]        rf1_idx_o,
   output logic [DW_BITS-1:0]       rf1_data_o,
   output logic                     flag_we_o,
   output logic                     flag_val_o,
   output logic                     align_err_o,
   output logic                     pair_err_o,
   output logic [ADDR_W-1:0]        ld_ea_o,
   output logic [EXC_W-1:0]         exc_o
);

   localparam int IDX_W    = $clog2(DEPTH);
   localparam int FLAG_IDX = FLAG_BIT - EXC_BASE;

   initial begin
      assert (FLAG_IDX >= 0 && FLAG_IDX < EXC_W)
         else $error("tqload_unit: flag bit outside the exception field");
      assert (REG_AW >= 1)
         else $error("tqload_unit: register index too narrow");
   end

   // ---------------- issue stage ----------------
   logic [ADDR_W-1:0] ea_d;
   logic              mis_d;
   logic [IDX_W-1:0]  qidx_d;
   fault_t            fault_d;
   logic              rd_en;

   tqload_agen #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W),
      .IDX_W  (IDX_W)
   ) u_agen (
      .base_i     (ld_base_i),
      .disp_i     (ld_disp_i),
      .ea_o       (ea_d),
      .misalign_o (mis_d),
      .qidx_o     (qidx_d)
   );

   always_comb begin
      fault_d.misalign = mis_d;
      fault_d.odd_pair = ld_rt_i[0];
      rd_en            = ld_valid_i & ~(|fault_d);
   end

   // ---------------- result stage registers ----------------
   logic              s1_vld;
   fault_t            s1_fault;
   logic [ADDR_W-1:0] s1_ea;
   logic [REG_AW-1:0] s1_rt;
   ptype_t            s1_mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld   <= 1'b0;
         s1_fault <= '0;
         s1_ea    <= '0;
         s1_rt    <= '0;
         s1_mask  <= '0;
      end else begin
         s1_vld <= ld_valid_i;
         if (ld_valid_i) begin
            s1_fault <= fault_d;
            s1_ea    <= ea_d;
            s1_rt    <= ld_rt_i;
            s1_mask  <= ld_mask_i;
         end
      end
   end

   // ---------------- tagged storage ----------------
   qword_t rd_data;
   logic   rd_tag;

   tqload_mem #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W)
   ) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en_i   (rd_en),
      .rd_idx_i  (qidx_d),
      .rd_data_o (rd_data),
      .rd_tag_o  (rd_tag),
      .wr_en_i   (st_valid_i),
      .wr_idx_i  (st_qidx_i),
      .wr_data_i (st_data_i),
      .wr_ptr_i  (st_ptr_i)
   );

   // ---------------- pointer check ----------------
   logic match;

   tqload_check #(
      .STRICT (STRICT_TYPE)
   ) u_check (
      .type_i  (ptype_of(rd_data)),
      .mask_i  (s1_mask),
      .tag_i   (rd_tag),
      .match_o (match)
   );

   // ---------------- result outputs ----------------
   logic s1_ok;

   always_comb begin
      s1_ok       = s1_vld & ~(|s1_fault);
      rf0_we_o    = s1_ok;
      rf1_we_o    = s1_ok;
      rf0_idx_o   = s1_rt;
      rf1_idx_o   = {s1_rt[REG_AW-1:1], 1'b1};
      rf0_data_o  = first_dw(rd_data);
      rf1_data_o  = second_dw(rd_data);
      flag_we_o   = s1_ok;
      flag_val_o  = s1_ok & match;
      align_err_o = s1_vld & s1_fault.misalign;
      pair_err_o  = s1_vld & s1_fault.odd_pair;
      ld_ea_o     = s1_ea;
   end

   // ---------------- extended exception field ----------------
   logic [EXC_W-1:0] exc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         exc_q <= '0;
      else if (flag_we_o) exc_q[FLAG_IDX] <= flag_val_o;
   end

   assign exc_o = exc_q;

   AST_WRITE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
      rf0_we_o |-> $past(ld_valid_i));                                   // R2

   AST_PAIR_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
      rf0_we_o |-> (rf1_we_o && rf1_idx_o == REG_AW'(rf0_idx_o + 1'b1))); // R2

   AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (align_err_o || pair_err_o) |-> (!rf0_we_o && !rf1_we_o && !flag_we_o)); // R8

   AST_FAULT_HOLDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (align_err_o || pair_err_o) |=> $stable(exc_o));                   // R8

   AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we_o |=> (exc_o[FLAG_IDX] == $past(flag_val_o)));             // R7

endmodule

// File: tb/tqload_unit_bench.sv
module tqload_unit_bench;

   localparam int ADDR_W = 32;
   localparam int DISP_W = 12;
   localparam int REG_AW = 5;
   localparam int DEPTH  = 64;
   localparam int IDX_W  = 6;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               ld_valid = 1'b0;
   logic [ADDR_W-1:0]  ld_base = '0;
   logic [DISP_W-1:0]  ld_disp = '0;
   logic [REG_AW-1:0]  ld_rt = '0;
   logic [3:0]         ld_mask = '0;
   logic               st_valid = 1'b0;
   logic [IDX_W-1:0]   st_qidx = '0;
   logic [127:0]       st_data = '0;
   logic               st_ptr = 1'b0;
   logic               rf0_we, rf1_we, flag_we, flag_val, align_err, pair_err;
   logic [REG_AW-1:0]  rf0_idx, rf1_idx;
   logic [63:0]        rf0_data, rf1_data;
   logic [ADDR_W-1:0]  ld_ea;
   logic [15:0]        exc;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   tqload_unit u_tqload_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_valid_i  (ld_valid),
      .ld_base_i   (ld_base),
      .ld_disp_i   (ld_disp),
      .ld_rt_i     (ld_rt),
      .ld_mask_i   (ld_mask),
      .st_valid_i  (st_valid),
      .st_qidx_i   (st_qidx),
      .st_data_i   (st_data),
      .st_ptr_i    (st_ptr),
      .rf0_we_o    (rf0_we),
      .rf0_idx_o   (rf0_idx),
      .rf0_data_o  (rf0_data),
      .rf1_we_o    (rf1_we),
      .rf1_idx_o   (rf1_idx),
      .rf1_data_o  (rf1_data),
      .flag_we_o   (flag_we),
      .flag_val_o  (flag_val),
      .align_err_o (align_err),
      .pair_err_o  (pair_err),
      .ld_ea_o     (ld_ea),
      .exc_o       (exc)
   );

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_store(input logic [IDX_W-1:0] idx, input logic [127:0] d,
                           input logic ptr);
      @(negedge clk);
      st_valid = 1'b1; st_qidx = idx; st_data = d; st_ptr = ptr;
      @(posedge clk);
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   // returns at the falling edge after the issuing edge: result cycle
   task automatic do_load(input logic [31:0] b, input logic [11:0] d,
                          input logic [4:0] rt, input logic [3:0] m);
      @(negedge clk);
      ld_valid = 1'b1; ld_base = b; ld_disp = d; ld_rt = rt; ld_mask = m;
      @(posedge clk);
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   task automatic check_fault(input string req, input logic [15:0] exc_before,
                              input bit exp_al, input bit exp_pr);
      chk(req, "align_err", align_err, exp_al);
      chk(req, "pair_err", pair_err, exp_pr);
      chk(req, "rf0_we", rf0_we, 0);
      chk(req, "rf1_we", rf1_we, 0);
      chk(req, "flag_we", flag_we, 0);
      @(negedge clk);
      chk(req, "exc unchanged", exc, exc_before);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R2 watchdog: actual still running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [63:0] hi, lo;
      logic [31:0] b, exp_ea;
      logic [11:0] d;
      logic [4:0]  rt;
      int          combo, idx;
      bit          exp_flag;

      // ---- R11: reset state ----
      repeat (3) @(negedge clk);
      chk("R11", "rf0_we in reset", rf0_we, 0);
      chk("R11", "exc in reset", exc, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11", "rf0_we", rf0_we, 0);
      chk("R11", "rf1_we", rf1_we, 0);
      chk("R11", "flag_we", flag_we, 0);
      chk("R11", "align_err", align_err, 0);
      chk("R11", "pair_err", pair_err, 0);
      chk("R11", "exc", exc, 0);

      // ---- R3: reset clears tags, keeps data ----
      do_store(6'd30, {60'h0_1234_5678, 4'b0001, 64'h55}, 1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      do_load(32'd30 * 16, 12'h000, 5'd2, 4'b1111);
      chk("R3", "flag after reset (tag cleared)", flag_val, 0);
      chk("R3", "data kept over reset", rf0_data, {60'h0_1234_5678, 4'b0001});

      // ---- sweep over type field, mask and tag: R1 R2 R4 R5 R6 R7 ----
      for (int t = 0; t < 16; t++) begin
         for (int m = 0; m < 16; m++) begin
            for (int g = 0; g < 2; g++) begin
               combo = t * 32 + m * 2 + g;
               idx   = combo % DEPTH;
               rt    = 5'((combo % 16) * 2);
               hi    = {60'(combo * 7 + 3), 4'(t)};
               lo    = 64'h0123_4567_89AB_CDEF ^ 64'(combo);
               do_store(6'(idx), {hi, lo}, 1'(g));
               if (combo % 2 == 0) begin
                  b = 32'(idx * 16) + 32'h100; d = 12'hF00; exp_ea = 32'(idx * 16);
               end else begin
                  b = 32'h0005_0000 + 32'(idx * 16) - 32'h40; d = 12'h040;
                  exp_ea = 32'h0005_0000 + 32'(idx * 16);
               end
               exp_flag = (g == 1) && ((t & m) != 0) && ($countones(4'(t)) == 1);
               do_load(b, d, rt, 4'(m));
               chk("R1", "effective address", ld_ea, exp_ea);
               chk("R2", "rf0_we/rf1_we", {rf0_we, rf1_we}, 2'b11);
               chk("R2", "register pair index", {rf0_idx, rf1_idx}, {rt, rt + 5'd1});
               chk("R2", "first doubleword", rf0_data, hi);
               chk("R2", "second doubleword", rf1_data, lo);
               chk("R7", "flag_we with writes", flag_we, 1);
               if ($countones(4'(t)) == 1)
                  chk("R5", "flag_val", flag_val, exp_flag);
               else
                  chk("R6", "flag_val malformed type", flag_val, exp_flag);
               @(negedge clk);
               chk("R7", "exc after update", exc, {6'b0, exp_flag, 9'b0});
            end
         end
      end

      // ---- R4: mask 0110 accepts instruction and space pointers only ----
      for (int k = 0; k < 4; k++) begin
         do_store(6'd40, {60'hABC, 4'(1 << k), 64'h9}, 1'b1);
         do_load(32'd40 * 16, 12'h000, 5'd8, 4'b0110);
         chk("R4", "mask 0110", flag_val, (k == 1 || k == 2));
      end

      // ---- R8: misaligned, flag held at 1 then at 0 ----
      do_store(6'd5, {60'h77, 4'b0100, 64'h1}, 1'b1);
      do_load(32'd80, 12'h000, 5'd2, 4'b0100);
      @(negedge clk);
      chk("R8", "setup flag set", exc, 16'h0200);
      for (int off = 1; off < 16; off++) begin
         do_load(32'd80 + 32'(off), 12'h000, 5'd2, 4'b0001);
         check_fault("R8", 16'h0200, 1'b1, 1'b0);
      end
      do_load(32'd80, 12'h003, 5'd2, 4'b0001);
      check_fault("R8", 16'h0200, 1'b1, 1'b0);
      do_load(32'd80, 12'h000, 5'd2, 4'b1000);
      @(negedge clk);
      chk("R8", "setup flag clear", exc, 16'h0000);
      do_load(32'd87, 12'h000, 5'd2, 4'b0100);
      check_fault("R8", 16'h0000, 1'b1, 1'b0);

      // ---- R9: odd destination register ----
      do_load(32'd80, 12'h000, 5'd7, 4'b0100);
      check_fault("R9", 16'h0000, 1'b0, 1'b1);
      do_load(32'd81, 12'h000, 5'd3, 4'b0100);
      check_fault("R9", 16'h0000, 1'b1, 1'b1);

      // ---- R3: ordinary store clears tag, pointer store sets it ----
      do_store(6'd10, {60'h5, 4'b0010, 64'h2}, 1'b1);
      do_load(32'd160, 12'h000, 5'd4, 4'b0010);
      chk("R3", "tagged pointer matches", flag_val, 1);
      do_store(6'd10, {60'h5, 4'b0010, 64'h2}, 1'b0);
      do_load(32'd160, 12'h000, 5'd4, 4'b0010);
      chk("R3", "plain store cleared tag", flag_val, 0);
      do_store(6'd10, {60'h5, 4'b0010, 64'h2}, 1'b1);
      do_load(32'd160, 12'h000, 5'd4, 4'b0010);
      chk("R3", "pointer store set tag", flag_val, 1);

      // ---- R10: same-edge store and load ----
      do_store(6'd20, {60'hAAA, 4'b0100, 64'hA0}, 1'b1);
      @(negedge clk);
      st_valid = 1'b1; st_qidx = 6'd20; st_data = {60'hBBB, 4'b0100, 64'hB0}; st_ptr = 1'b0;
      ld_valid = 1'b1; ld_base = 32'd320; ld_disp = 12'h000; ld_rt = 5'd4; ld_mask = 4'b0100;
      @(posedge clk);
      @(negedge clk);
      st_valid = 1'b0; ld_valid = 1'b0;
      chk("R10", "old data on same edge", rf0_data, {60'hAAA, 4'b0100});
      chk("R10", "old tag on same edge", flag_val, 1);
      do_load(32'd320, 12'h000, 5'd4, 4'b0100);
      chk("R10", "new data afterwards", rf0_data, {60'hBBB, 4'b0100});
      chk("R10", "new tag afterwards", flag_val, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule